// File: doc/BRIEF.md
# Host Command Packet Dispatcher with Seconds Clock

This block sits between a host-side transport and the system-management logic of a chip. The host delivers a complete packet as a stream of bytes closed by an end strobe. The first byte gives the packet class and the second gives the command. Control-class packets are decoded at once. Each command's argument count is checked exactly, the command is executed, and a framed reply is placed in a response buffer. The host then reads that buffer by address and releases it with an acknowledge. Bus-device packets are passed to a simple request/response port. The device's reply, or an unsolicited autopoll frame from it, is framed with the matching header before the host sees it.

The block keeps the poll controls: the enable, the rate, and the 16-bit device mask. It issues one-cycle power-down and system-reset requests. It also keeps a 32-bit seconds clock whose zero is the start of 1904. The clock is stored as an offset plus an elapsed-tick count, and it advances on a one-second tick input. Only one response exists at a time. While a response is waiting, neither the host nor the device port can start anything new.

Top module: `pkt_cmd_dispatch`

## Requirements
- R1: After reset, no response is pending, `in_rdy` and `dev_rdy` are 1, polling is disabled, the rate is 11, and the mask is 0.
- R2: A control packet (class byte 1) whose command is known and whose argument count is correct is answered with {1, 0, command} followed by any result bytes.
- R3: A known control command with the wrong argument count is answered with {2, 5, 1, command} and has no effect on any output.
- R4: A control command that matches none of the command parameters is answered with {2, 2, 1, command}.
- R5: The autopoll-enable command (default code 0x01) takes exactly one argument, and any nonzero value enables polling.
- R6: The poll-rate command (default code 0x14) takes exactly one argument. A value of 0 is rejected as a bad parameter (R3 framing) and leaves the rate unchanged.
- R7: The device-mask command (default code 0x19) takes exactly two bytes. The first byte becomes bits 15:8 of `ap_mask`.
- R8: Power-down (default code 0x0A) and system reset (default code 0x11) take no arguments. Each raises its request output for exactly one cycle.
- R9: Get-time (default code 0x03) takes no arguments and returns the 32-bit seconds value as four bytes, most significant first. After reset the value is 2082844800 plus `UNIX_AT_RESET`, and it advances by one for each `sec_tick`.
- R10: Set-time (default code 0x09) takes exactly four bytes, most significant first. Later reads return the written value plus the ticks seen since the write, wrapping modulo 2^32.
- R11: A class-0 packet of at least two bytes pulses `dev_req` with the command, the argument count, and the first two arguments. Replies are framed as follows: a success reply is {0, 0x00, data…}; a nonzero `dev_err` gives {0, dev_err, command}; a reply marked `dev_poll` gives {0, 0x40, data…}.
- R12: A packet shorter than two bytes, or one whose class is neither 0 nor 1, produces no response and changes no output.
- R13: While a response is pending, `in_rdy` and `dev_rdy` are 0, and the length and contents stay stable until `rsp_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Host packet byte valid |
| in_byte | input | 8 | Host packet byte |
| in_end | input | 1 | Closes the host packet (a byte on the same cycle is included) |
| in_rdy | output | 1 | Host bytes and end strobe are accepted |
| rsp_valid | output | 1 | A response is held in the buffer |
| rsp_len | output | RLW | Response length in bytes |
| rsp_addr | input | RAW | Response read address |
| rsp_data | output | 8 | Response byte, one cycle after the address |
| rsp_ack | input | 1 | Releases the pending response |
| dev_req | output | 1 | One-cycle bus-device request |
| dev_cmd | output | 8 | Bus-device command byte |
| dev_arg | output | 16 | First two argument bytes, first in bits 15:8 |
| dev_argc | output | LW | Bus-device argument count |
| dev_wr | input | 1 | Device reply byte valid |
| dev_byte | input | 8 | Device reply byte |
| dev_end | input | 1 | Closes the device reply |
| dev_err | input | 8 | Error code sampled with `dev_end`, 0 means success |
| dev_poll | input | 1 | Reply is autopolled data, sampled with `dev_end` |
| dev_rdy | output | 1 | Device reply bytes and end strobe are accepted |
| sec_tick | input | 1 | One-second tick |
| ap_en | output | 1 | Autopoll enable |
| ap_rate | output | 8 | Autopoll rate |
| ap_mask | output | 16 | Autopoll device mask |
| shut_req | output | 1 | Power-down request pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
The bench targets argument-count boundaries: one too few, one too many, and a zero rate. A design that checked `>=` instead of `==`, or accepted a zero rate, would answer with a success header and change outputs that must hold. Set-time near 0xFFFFFFFF followed by ticks targets the 32-bit wrap. The argument-byte order of the mask and the time is checked with asymmetric values, so swapped halves show up as wrong bytes. The bench also covers the device error frame, which must echo the saved command rather than payload data, and unsolicited poll frames. Bytes pushed while a response is pending must not enter the next packet; a design that ignored the busy flag would misparse the following command.

// File: rtl/pktd_pkg.sv
package pktd_pkg;
  localparam logic [7:0] CLS_DEV       = 8'd0;
  localparam logic [7:0] CLS_CTRL      = 8'd1;
  localparam logic [7:0] CLS_ERR       = 8'd2;
  localparam logic [7:0] CAUSE_UNKNOWN = 8'h02;
  localparam logic [7:0] CAUSE_BADARG  = 8'h05;
  localparam logic [7:0] POLL_TAG      = 8'h40;
  localparam int         HDR_BYTES     = 7;
  localparam int         HEAD_BYTES    = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_DWAIT, ST_WRHDR} st_e;

  typedef struct packed {
    logic        ap_wr;
    logic        ap_val;
    logic        rate_wr;
    logic [7:0]  rate_val;
    logic        mask_wr;
    logic [15:0] mask_val;
    logic        pwr;
    logic        sys;
    logic        time_wr;
    logic [31:0] time_val;
  } act_t;
endpackage

// File: rtl/pktd_inbuf.sv
module pktd_inbuf import pktd_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [7:0]              wbyte,
  input  logic                    clr,
  output logic [LW-1:0]           cnt,
  output logic [HEAD_BYTES*8-1:0] head
);
  // register file: the decoder reads the first bytes in parallel
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr && cnt < LW'(DEPTH)) begin
      mem[cnt[AW-1:0]] <= wbyte;
      cnt <= cnt + LW'(1);
    end
  end

  for (genvar i = 0; i < HEAD_BYTES; i++) begin : g_head
    assign head[i*8 +: 8] = mem[i];
  end
endmodule

// File: rtl/pktd_rtc.sv
module pktd_rtc #(
  parameter logic [31:0] EPOCH_GAP     = 32'd2082844800,
  parameter logic [31:0] UNIX_AT_RESET = 32'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        set,
  input  logic [31:0] set_val,
  output logic [31:0] now
);
  localparam logic [31:0] RESET_SECS = EPOCH_GAP + UNIX_AT_RESET;
  logic [31:0] elapsed, offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      offset  <= RESET_SECS;
    end else begin
      elapsed <= elapsed + 32'(tick);
      if (set) offset <= set_val - elapsed;
    end
  end

  assign now = offset + elapsed;
endmodule

// File: rtl/pktd_decode.sv
module pktd_decode import pktd_pkg::*; #(
  parameter int LW = 5,
  parameter logic [7:0] CMD_AUTOPOLL = 8'h01,
  parameter logic [7:0] CMD_RATE     = 8'h14,
  parameter logic [7:0] CMD_DEVLIST  = 8'h19,
  parameter logic [7:0] CMD_PWRDN    = 8'h0A,
  parameter logic [7:0] CMD_SYSRST   = 8'h11,
  parameter logic [7:0] CMD_GETTIME  = 8'h03,
  parameter logic [7:0] CMD_SETTIME  = 8'h09
) (
  input  logic [HEAD_BYTES*8-1:0] head,
  input  logic [LW-1:0]           len,
  input  logic [31:0]             now,
  output logic                    respond,
  output logic                    forward,
  output logic [HDR_BYTES*8-1:0]  hdr,
  output logic [3:0]              hdr_n,
  output act_t                    act
);
  logic [7:0] b [HEAD_BYTES];
  for (genvar i = 0; i < HEAD_BYTES; i++) begin : g_b
    assign b[i] = head[i*8 +: 8];
  end

  logic [LW-1:0] argc;
  logic          known, ok, has_time;

  always_comb begin
    argc     = len - LW'(2);
    respond  = 1'b0;
    forward  = 1'b0;
    hdr      = '0;
    hdr_n    = 4'd0;
    act      = '0;
    known    = 1'b1;
    ok       = 1'b0;
    has_time = 1'b0;
    if (len >= LW'(2)) begin
      if (b[0] == CLS_DEV) begin
        forward = 1'b1;
      end else if (b[0] == CLS_CTRL) begin
        respond = 1'b1;
        if (b[1] == CMD_AUTOPOLL) begin
          ok = (argc == LW'(1));
          act.ap_wr  = 1'b1;
          act.ap_val = (b[2] != 8'd0);
        end else if (b[1] == CMD_RATE) begin
          ok = (argc == LW'(1)) && (b[2] != 8'd0);
          act.rate_wr  = 1'b1;
          act.rate_val = b[2];
        end else if (b[1] == CMD_DEVLIST) begin
          ok = (argc == LW'(2));
          act.mask_wr  = 1'b1;
          act.mask_val = {b[2], b[3]};
        end else if (b[1] == CMD_PWRDN) begin
          ok = (argc == LW'(0));
          act.pwr = 1'b1;
        end else if (b[1] == CMD_SYSRST) begin
          ok = (argc == LW'(0));
          act.sys = 1'b1;
        end else if (b[1] == CMD_GETTIME) begin
          ok = (argc == LW'(0));
          has_time = 1'b1;
        end else if (b[1] == CMD_SETTIME) begin
          ok = (argc == LW'(4));
          act.time_wr  = 1'b1;
          act.time_val = {b[2], b[3], b[4], b[5]};
        end else begin
          known = 1'b0;
        end
        if (!ok) act = '0;
        if (known && ok) begin
          hdr[7:0]   = CLS_CTRL;
          hdr[15:8]  = 8'd0;
          hdr[23:16] = b[1];
          hdr_n      = 4'd3;
          if (has_time) begin
            hdr[31:24] = now[31:24];
            hdr[39:32] = now[23:16];
            hdr[47:40] = now[15:8];
            hdr[55:48] = now[7:0];
            hdr_n      = 4'd7;
          end
        end else begin
          hdr[7:0]   = CLS_ERR;
          hdr[15:8]  = known ? CAUSE_BADARG : CAUSE_UNKNOWN;
          hdr[23:16] = CLS_CTRL;
          hdr[31:24] = b[1];
          hdr_n      = 4'd4;
        end
      end
    end
  end
endmodule

// File: rtl/pktd_rspbuf.sv
module pktd_rspbuf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pkt_cmd_dispatch.sv
module pkt_cmd_dispatch import pktd_pkg::*; #(
  parameter int IN_DEPTH  = 16,
  parameter int RSP_DEPTH = 16,
  parameter logic [7:0] CMD_AUTOPOLL = 8'h01,
  parameter logic [7:0] CMD_RATE     = 8'h14,
  parameter logic [7:0] CMD_DEVLIST  = 8'h19,
  parameter logic [7:0] CMD_PWRDN    = 8'h0A,
  parameter logic [7:0] CMD_SYSRST   = 8'h11,
  parameter logic [7:0] CMD_GETTIME  = 8'h03,
  parameter logic [7:0] CMD_SETTIME  = 8'h09,
  parameter logic [7:0] RATE_INIT    = 8'd11,
  parameter logic [31:0] UNIX_AT_RESET = 32'd0,
  localparam int LW  = $clog2(IN_DEPTH + 1),
  localparam int RAW = $clog2(RSP_DEPTH),
  localparam int RLW = $clog2(RSP_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic [7:0]     in_byte,
  input  logic           in_end,
  output logic           in_rdy,
  output logic           rsp_valid,
  output logic [RLW-1:0] rsp_len,
  input  logic [RAW-1:0] rsp_addr,
  output logic [7:0]     rsp_data,
  input  logic           rsp_ack,
  output logic           dev_req,
  output logic [7:0]     dev_cmd,
  output logic [15:0]    dev_arg,
  output logic [LW-1:0]  dev_argc,
  input  logic           dev_wr,
  input  logic [7:0]     dev_byte,
  input  logic           dev_end,
  input  logic [7:0]     dev_err,
  input  logic           dev_poll,
  output logic           dev_rdy,
  input  logic           sec_tick,
  output logic           ap_en,
  output logic [7:0]     ap_rate,
  output logic [15:0]    ap_mask,
  output logic           shut_req,
  output logic           reset_req
);
  st_e                    st;
  logic [LW-1:0]          in_cnt, pkt_len, len_nx;
  logic [HEAD_BYTES*8-1:0] head;
  logic [RLW-1:0]         dev_cnt, dev_cnt_nx, len_pend;
  logic [HDR_BYTES*8-1:0] hdr, dec_hdr, dev_hdr;
  logic [3:0]             hdr_n, dec_n, dev_n;
  logic [RLW-1:0]         dev_len;
  logic [2:0]             wi;
  logic [7:0]             last_cmd;
  logic                   in_take, dev_put, dec_respond, dec_forward;
  logic [31:0]            now;
  act_t                   dec_act;
  logic                   we;
  logic [RAW-1:0]         waddr;
  logic [7:0]             wdata;

  assign in_rdy  = (st == ST_IDLE) && !rsp_valid && (dev_cnt == '0);
  assign dev_rdy = !rsp_valid && ((st == ST_DWAIT) ||
                   ((st == ST_IDLE) && (in_cnt == '0) && !in_vld && !in_end));
  assign in_take    = in_vld && in_rdy;
  assign len_nx     = in_cnt + LW'(in_take && (in_cnt < LW'(IN_DEPTH)));
  assign dev_put    = dev_wr && dev_rdy && (dev_cnt < RLW'(RSP_DEPTH - 2));
  assign dev_cnt_nx = dev_cnt + RLW'(dev_put);

  pktd_inbuf #(.DEPTH(IN_DEPTH)) u_inbuf (
    .clk(clk), .rst(rst), .wr(in_take), .wbyte(in_byte),
    .clr(st == ST_EXEC), .cnt(in_cnt), .head(head)
  );

  pktd_rtc #(.UNIX_AT_RESET(UNIX_AT_RESET)) u_rtc (
    .clk(clk), .rst(rst), .tick(sec_tick),
    .set((st == ST_EXEC) && dec_act.time_wr), .set_val(dec_act.time_val), .now(now)
  );

  pktd_decode #(
    .LW(LW), .CMD_AUTOPOLL(CMD_AUTOPOLL), .CMD_RATE(CMD_RATE),
    .CMD_DEVLIST(CMD_DEVLIST), .CMD_PWRDN(CMD_PWRDN), .CMD_SYSRST(CMD_SYSRST),
    .CMD_GETTIME(CMD_GETTIME), .CMD_SETTIME(CMD_SETTIME)
  ) u_dec (
    .head(head), .len(pkt_len), .now(now), .respond(dec_respond),
    .forward(dec_forward), .hdr(dec_hdr), .hdr_n(dec_n), .act(dec_act)
  );

  // header for a device reply or an unsolicited poll frame
  always_comb begin
    dev_hdr = '0;
    dev_hdr[7:0] = CLS_DEV;
    if (dev_err != 8'd0) begin
      dev_hdr[15:8]  = dev_err;
      dev_hdr[23:16] = last_cmd;
      dev_n   = 4'd3;
      dev_len = RLW'(3);
    end else begin
      dev_hdr[15:8] = dev_poll ? POLL_TAG : 8'h00;
      dev_n   = 4'd2;
      dev_len = RLW'(2) + dev_cnt_nx;
    end
  end

  assign we    = (st == ST_WRHDR) || dev_put;
  assign waddr = (st == ST_WRHDR) ? RAW'(wi) : RAW'(dev_cnt) + RAW'(2);
  assign wdata = (st == ST_WRHDR) ? hdr[{wi, 3'b000} +: 8] : dev_byte;

  pktd_rspbuf #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rsp_addr), .rdata(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pkt_len   <= '0;
      dev_cnt   <= '0;
      hdr       <= '0;
      hdr_n     <= 4'd0;
      wi        <= '0;
      last_cmd  <= 8'd0;
      len_pend  <= '0;
      rsp_valid <= 1'b0;
      rsp_len   <= '0;
      ap_en     <= 1'b0;
      ap_rate   <= RATE_INIT;
      ap_mask   <= '0;
      shut_req  <= 1'b0;
      reset_req <= 1'b0;
      dev_req   <= 1'b0;
      dev_cmd   <= 8'd0;
      dev_arg   <= '0;
      dev_argc  <= '0;
    end else begin
      shut_req  <= 1'b0;
      reset_req <= 1'b0;
      dev_req   <= 1'b0;
      dev_cnt   <= dev_cnt_nx;
      if (rsp_valid && rsp_ack) rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (in_rdy && in_end) begin
            pkt_len <= len_nx;
            st      <= ST_EXEC;
          end else if (dev_rdy && dev_end) begin
            hdr <= dev_hdr; hdr_n <= dev_n; len_pend <= dev_len;
            st  <= ST_WRHDR;
          end
        end
        ST_EXEC: begin
          if (dec_act.ap_wr)   ap_en    <= dec_act.ap_val;
          if (dec_act.rate_wr) ap_rate  <= dec_act.rate_val;
          if (dec_act.mask_wr) ap_mask  <= dec_act.mask_val;
          shut_req  <= dec_act.pwr;
          reset_req <= dec_act.sys;
          if (dec_respond) begin
            hdr <= dec_hdr; hdr_n <= dec_n; len_pend <= RLW'(dec_n);
            st  <= ST_WRHDR;
          end else if (dec_forward) begin
            dev_req  <= 1'b1;
            dev_cmd  <= head[15:8];
            last_cmd <= head[15:8];
            dev_arg  <= {head[23:16], head[31:24]};
            dev_argc <= pkt_len - LW'(2);
            st       <= ST_DWAIT;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_DWAIT: begin
          if (dev_end) begin
            hdr <= dev_hdr; hdr_n <= dev_n; len_pend <= dev_len;
            st  <= ST_WRHDR;
          end
        end
        ST_WRHDR: begin
          if ({1'b0, wi} == hdr_n - 4'd1) begin
            wi        <= '0;
            rsp_valid <= 1'b1;
            rsp_len   <= len_pend;
            dev_cnt   <= '0;
            st        <= ST_IDLE;
          end else begin
            wi <= wi + 3'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pktd_chk.sv
module pktd_chk #(
  parameter int RLW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           rsp_valid,
  input logic           rsp_ack,
  input logic [RLW-1:0] rsp_len,
  input logic           in_rdy,
  input logic           dev_rdy,
  input logic           dev_req,
  input logic           shut_req,
  input logic           reset_req,
  input logic [7:0]     ap_rate
);
  // R13
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_len));
  // R13
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !in_rdy && !dev_rdy);
  // R2
  rsp_len_min_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_len >= RLW'(2));
  // R8
  shut_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    shut_req |=> !shut_req);
  // R8
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  // R6
  rate_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    $changed(ap_rate) |-> ap_rate != 8'd0);
  // R11
  dev_wait_chk: assert property (@(posedge clk) disable iff (rst)
    dev_req |-> !in_rdy && !rsp_valid);
endmodule

bind pkt_cmd_dispatch pktd_chk #(.RLW(RLW)) u_chk (
  .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
  .rsp_len(rsp_len), .in_rdy(in_rdy), .dev_rdy(dev_rdy), .dev_req(dev_req),
  .shut_req(shut_req), .reset_req(reset_req), .ap_rate(ap_rate)
);

// File: tb/tb_pkt_cmd_dispatch.sv
module tb_pkt_cmd_dispatch;
  localparam logic [7:0] C_AP = 8'h01, C_RATE = 8'h14, C_MASK = 8'h19,
                         C_PWR = 8'h0A, C_SYS = 8'h11, C_GET = 8'h03, C_SET = 8'h09;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic in_vld = 0, in_end = 0, rsp_ack = 0, dev_wr = 0, dev_end = 0, dev_poll = 0, sec_tick = 0;
  logic [7:0] in_byte = 0, dev_byte = 0, dev_err = 0;
  logic [3:0] rsp_addr = 0;
  logic in_rdy, rsp_valid, dev_req, dev_rdy, ap_en, shut_req, reset_req;
  logic [4:0] rsp_len, dev_argc;
  logic [7:0] rsp_data, dev_cmd, ap_rate;
  logic [15:0] dev_arg, ap_mask;

  pkt_cmd_dispatch dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte), .in_end(in_end),
    .in_rdy(in_rdy), .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .rsp_ack(rsp_ack), .dev_req(dev_req), .dev_cmd(dev_cmd),
    .dev_arg(dev_arg), .dev_argc(dev_argc), .dev_wr(dev_wr), .dev_byte(dev_byte),
    .dev_end(dev_end), .dev_err(dev_err), .dev_poll(dev_poll), .dev_rdy(dev_rdy),
    .sec_tick(sec_tick), .ap_en(ap_en), .ap_rate(ap_rate), .ap_mask(ap_mask),
    .shut_req(shut_req), .reset_req(reset_req)
  );

  int n_chk = 0, n_bad = 0, n_shut = 0, n_sys = 0;
  bit summary_done = 0;
  always @(posedge clk) begin
    if (shut_req === 1'b1) n_shut++;
    if (reset_req === 1'b1) n_sys++;
  end

  // model state
  logic        m_en = 0;
  logic [7:0]  m_rate = 8'd11;
  logic [15:0] m_mask = 0;
  logic [31:0] m_time = 32'd2082844800;
  logic [7:0]  pk [16];
  logic [7:0]  db [16];
  logic [7:0]  ex [16];
  logic [7:0]  got [16];
  int          ex_n, got_n, ex_shut, ex_sys;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 100 && in_rdy !== 1'b1; t++) @(negedge clk);
  endtask

  task automatic send(int n);
    wait_idle();
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_vld = 1; in_byte = pk[i];
    end
    @(negedge clk); in_vld = 0; in_end = 1;
    @(negedge clk); in_end = 0;
  endtask

  task automatic get_rsp();
    got_n = 0;
    for (int t = 0; t < 60 && rsp_valid !== 1'b1; t++) @(negedge clk);
    if (rsp_valid === 1'b1) got_n = int'(rsp_len);
    for (int i = 0; i < got_n && i < 16; i++) begin
      @(negedge clk); rsp_addr = 4'(i);
      @(negedge clk); got[i] = rsp_data;
    end
    if (rsp_valid === 1'b1) begin
      @(negedge clk); rsp_ack = 1;
      @(negedge clk); rsp_ack = 0;
    end
  endtask

  task automatic cmp_rsp(string req);
    chk({req, " length"}, 32'(got_n), 32'(ex_n));
    for (int i = 0; i < ex_n && i < got_n; i++) chk({req, " byte"}, {24'd0, got[i]}, {24'd0, ex[i]});
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
      m_time = m_time + 32'd1;
    end
  endtask

  // expected reply and side effects of a control packet in pk[0..argc+1]
  task automatic model_ctrl(int argc);
    logic [7:0] c = pk[1];
    bit known = 1, ok = 0, gt = 0;
    ex_shut = 0; ex_sys = 0;
    if (c == C_AP) begin ok = (argc == 1); if (ok) m_en = (pk[2] != 0); end
    else if (c == C_RATE) begin ok = (argc == 1) && (pk[2] != 0); if (ok) m_rate = pk[2]; end
    else if (c == C_MASK) begin ok = (argc == 2); if (ok) m_mask = {pk[2], pk[3]}; end
    else if (c == C_PWR) begin ok = (argc == 0); ex_shut = ok; end
    else if (c == C_SYS) begin ok = (argc == 0); ex_sys = ok; end
    else if (c == C_GET) begin ok = (argc == 0); gt = ok; end
    else if (c == C_SET) begin ok = (argc == 4); end
    else known = 0;
    if (known && ok) begin
      ex[0] = 1; ex[1] = 0; ex[2] = c; ex_n = 3;
      if (gt) begin
        ex[3] = m_time[31:24]; ex[4] = m_time[23:16]; ex[5] = m_time[15:8]; ex[6] = m_time[7:0]; ex_n = 7;
      end
      if (c == C_SET) m_time = {pk[2], pk[3], pk[4], pk[5]};
    end else begin
      ex[0] = 2; ex[1] = known ? 8'd5 : 8'd2; ex[2] = 1; ex[3] = c; ex_n = 4;
    end
  endtask

  task automatic run_ctrl(int argc, string req);
    int s0 = n_shut, y0 = n_sys;
    pk[0] = 8'd1;
    model_ctrl(argc);
    send(argc + 2);
    get_rsp();
    cmp_rsp(req);
    chk({req, " R5 ap_en"}, {31'd0, ap_en}, {31'd0, m_en});
    chk({req, " R6 ap_rate"}, {24'd0, ap_rate}, {24'd0, m_rate});
    chk({req, " R7 ap_mask"}, {16'd0, ap_mask}, {16'd0, m_mask});
    chk({req, " R8 shutdown pulses"}, 32'(n_shut - s0), 32'(ex_shut));
    chk({req, " R8 reset pulses"}, 32'(n_sys - y0), 32'(ex_sys));
  endtask

  task automatic dev_stream(int n, logic [7:0] err, logic poll);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dev_wr = 1; dev_byte = db[i];
    end
    @(negedge clk); dev_wr = 0; dev_end = 1; dev_err = err; dev_poll = poll;
    @(negedge clk); dev_end = 0; dev_err = 0; dev_poll = 0;
  endtask

  task automatic run_ignored(int n, string req);
    send(n);
    repeat (10) @(negedge clk);
    chk({req, " no response"}, {31'd0, rsp_valid}, 32'd0);
    chk({req, " ready again"}, {31'd0, in_rdy}, 32'd1);
    chk({req, " mask kept"}, {16'd0, ap_mask}, {16'd0, m_mask});
  endtask

  task automatic wait_dev_req();
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (dev_req === 1'b1) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 in_rdy", {31'd0, in_rdy}, 32'd1);
    chk("R1 dev_rdy", {31'd0, dev_rdy}, 32'd1);
    chk("R1 ap_en", {31'd0, ap_en}, 32'd0);
    chk("R1 ap_rate", {24'd0, ap_rate}, 32'd11);
    chk("R1 ap_mask", {16'd0, ap_mask}, 32'd0);

    // R9 time after reset
    pk[1] = C_GET; run_ctrl(0, "R9 get at reset");
    ticks(3);
    pk[1] = C_GET; run_ctrl(0, "R9 get after ticks");
    // R10 wrap
    pk[1] = C_SET; pk[2] = 8'hFF; pk[3] = 8'hFF; pk[4] = 8'hFF; pk[5] = 8'hFE;
    run_ctrl(4, "R10 set near wrap");
    ticks(3);
    pk[1] = C_GET; run_ctrl(0, "R10 get after wrap");
    // R5 / R6 / R7 / R8 / R3 / R4 directed
    pk[1] = C_AP; pk[2] = 8'h80; run_ctrl(1, "R5 enable nonzero");
    pk[1] = C_AP; pk[2] = 8'h01; pk[3] = 8'h00; run_ctrl(2, "R3 enable extra arg");
    pk[1] = C_RATE; pk[2] = 8'h00; run_ctrl(1, "R6 zero rate");
    pk[1] = C_RATE; pk[2] = 8'h07; run_ctrl(1, "R6 rate 7");
    pk[1] = C_MASK; pk[2] = 8'hA5; pk[3] = 8'h3C; run_ctrl(2, "R7 mask order");
    pk[1] = C_MASK; pk[2] = 8'h11; run_ctrl(1, "R3 mask short");
    pk[1] = C_PWR; run_ctrl(0, "R8 power-down");
    pk[1] = C_SYS; run_ctrl(0, "R8 system reset");
    pk[1] = C_SYS; pk[2] = 8'h00; run_ctrl(1, "R3 reset with arg");
    pk[1] = C_SET; pk[2] = 8'h01; pk[3] = 8'h02; pk[4] = 8'h03; run_ctrl(3, "R3 set short");
    pk[1] = 8'h77; run_ctrl(0, "R4 unknown");

    // R12 ignored packets
    pk[0] = 8'd5; pk[1] = C_MASK; pk[2] = 8'hFF; pk[3] = 8'hFF; run_ignored(4, "R12 class 5");
    pk[0] = 8'd1; run_ignored(1, "R12 one byte");
    run_ignored(0, "R12 empty");

    // R11 device success
    pk[0] = 8'd0; pk[1] = 8'h2C; pk[2] = 8'hAA; pk[3] = 8'h5B;
    send(4);
    wait_dev_req();
    chk("R11 dev_req", {31'd0, dev_req}, 32'd1);
    chk("R11 dev_cmd", {24'd0, dev_cmd}, 32'h2C);
    chk("R11 dev_argc", {27'd0, dev_argc}, 32'd2);
    chk("R11 dev_arg", {16'd0, dev_arg}, 32'hAA5B);
    db[0] = 8'h12; db[1] = 8'h34;
    dev_stream(2, 8'd0, 1'b0);
    get_rsp();
    ex[0] = 0; ex[1] = 0; ex[2] = 8'h12; ex[3] = 8'h34; ex_n = 4;
    cmp_rsp("R11 device reply");
    // R11 device error
    pk[1] = 8'h3C; send(2);
    wait_dev_req();
    db[0] = 8'h99;
    dev_stream(1, 8'h03, 1'b0);
    get_rsp();
    ex[0] = 0; ex[1] = 8'h03; ex[2] = 8'h3C; ex_n = 3;
    cmp_rsp("R11 device error");
    // R11 unsolicited poll
    @(negedge clk);
    chk("R11 dev_rdy idle", {31'd0, dev_rdy}, 32'd1);
    db[0] = 8'h55; db[1] = 8'h66; db[2] = 8'h77;
    dev_stream(3, 8'd0, 1'b1);
    get_rsp();
    ex[0] = 0; ex[1] = 8'h40; ex[2] = 8'h55; ex[3] = 8'h66; ex[4] = 8'h77; ex_n = 5;
    cmp_rsp("R11 poll frame");

    // R13 busy: bytes pushed while pending are dropped
    pk[0] = 8'd1; pk[1] = C_RATE; pk[2] = 8'h21;
    model_ctrl(1);
    send(3);
    for (int t = 0; t < 30 && rsp_valid !== 1'b1; t++) @(negedge clk);
    chk("R13 in_rdy while pending", {31'd0, in_rdy}, 32'd0);
    chk("R13 dev_rdy while pending", {31'd0, dev_rdy}, 32'd0);
    @(negedge clk); in_vld = 1; in_byte = 8'h01;
    @(negedge clk); in_vld = 0;
    repeat (4) @(negedge clk);
    chk("R13 still pending", {31'd0, rsp_valid}, 32'd1);
    get_rsp();
    cmp_rsp("R13 held response");
    pk[1] = C_GET; run_ctrl(0, "R13 next packet clean");

    // random mix
    for (int it = 0; it < 160; it++) begin
      int r = int'($urandom % 20);
      if (r < 15) begin
        int k = int'($urandom % 9);
        int argc;
        case (k)
          0: pk[1] = C_AP;   1: pk[1] = C_RATE; 2: pk[1] = C_MASK;
          3: pk[1] = C_PWR;  4: pk[1] = C_SYS;  5: pk[1] = C_GET;
          6: pk[1] = C_SET;  default: pk[1] = 8'($urandom);
        endcase
        if ($urandom % 2 == 0) begin
          case (k) 0, 1: argc = 1; 2: argc = 2; 6: argc = 4; default: argc = 0; endcase
        end else argc = int'($urandom % 5);
        for (int i = 2; i < 6; i++) pk[i] = 8'($urandom);
        if ($urandom % 4 == 0) pk[2] = 8'd0;
        run_ctrl(argc, "R2 random control");
      end else if (r < 17) begin
        pk[0] = 8'd0; pk[1] = 8'($urandom);
        send(2);
        wait_dev_req();
        chk("R11 random dev_cmd", {24'd0, dev_cmd}, {24'd0, pk[1]});
        db[0] = 8'($urandom);
        dev_stream(1, 8'd0, 1'b0);
        get_rsp();
        ex[0] = 0; ex[1] = 0; ex[2] = db[0]; ex_n = 3;
        cmp_rsp("R11 random reply");
      end else begin
        pk[0] = 8'd2 + 8'($urandom % 254); pk[1] = 8'($urandom);
        run_ignored(2, "R12 random class");
      end
      ticks(int'($urandom % 3));
    end
    summary();
  end
endmodule